// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor

This block decides, for each load about to issue, whether it may go ahead of older stores or must wait. It learns from ordering violations: when the memory pipeline reports that a load ran ahead of a store it depended on, the two instruction addresses are placed in a common store set. From then on, each dispatched store that belongs to a set marks itself as the newest outstanding member of that set. A load in the same set is held until that store's address is known. Loads that have never caused a violation are never held.

Two tables hold this state. A 1024-entry table indexed by instruction address maps each load or store to an optional 6-bit set number. A 64-entry table indexed by set number records which store, identified by its queue tag, is the newest member of the set whose address is still unknown. A free-running timer wipes both tables at a fixed interval, so that associations built up by table aliasing do not stay forever. The load/store queue and the actual address comparison are outside this block.

Top module: `ssp_predictor`

## Requirements
- R1: After reset both tables are empty. `lq_stall` is 0 whenever `lq_valid` is 0, and it is 0 for every load query while no training has occurred.
- R2: The address table is indexed by PC bits [11:2] (ALIGN=2, IDX_W=10). Two PCs that differ only in bits [1:0] or in bits above 11 share one entry.
- R3: A training event in which neither PC has a set number gives both PCs a new number taken from a 6-bit allocation counter. The counter starts at 0 after reset, advances by one for each such event, wraps from 63 to 0, and is not reset by the periodic clear.
- R4: A training event in which exactly one PC has a set number gives the other PC that same number.
- R5: A training event in which both PCs have set numbers writes the smaller of the two numbers to both entries.
- R6: A dispatched store whose PC has a set number records its tag as the pending store of that set, replacing any earlier one. A dispatched store whose PC has no set number changes nothing.
- R7: A load query stalls (`lq_stall`=1 in the same cycle) exactly when its PC has a set number and that set has a pending store. The answer reflects all updates from earlier clock edges and none from the current cycle.
- R8: A resolved-address report clears every pending-store entry whose recorded tag equals the reported tag and leaves entries with other tags alone. If a dispatch writes a set in the same cycle, the dispatch wins for that set.
- R9: Every CLR_INTERVAL cycles (the cycles numbered CLR_INTERVAL-1, 2*CLR_INTERVAL-1, ... counting from 0 at the first clock edge after reset) both tables are emptied, and any training, dispatch or resolve presented in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trn_valid | input | 1 | Ordering violation reported this cycle |
| trn_load_pc | input | PC_W | PC of the load that ran too early |
| trn_store_pc | input | PC_W | PC of the store it depended on |
| disp_valid | input | 1 | A store is dispatched this cycle |
| disp_pc | input | PC_W | PC of the dispatched store |
| disp_tag | input | TAG_W | Queue tag of the dispatched store |
| res_valid | input | 1 | A store's address became known this cycle |
| res_tag | input | TAG_W | Queue tag of that store |
| lq_valid | input | 1 | A load asks whether it may proceed |
| lq_pc | input | PC_W | PC of the asking load |
| lq_stall | output | 1 | 1: hold the load; 0: let it go |

## Verification
The reference model is tried first with hand-built sequences: fresh pairs, one-sided and two-sided merges, aliased PCs, stores without a set, wrong-tag and right-tag resolves, and a dispatch racing a resolve on the same set, which together separate the merge rules from one another and show whether the tag compare is really made. A run of seventy fresh pairs wraps the allocation counter, so a new pair lands on an old set number, which shows whether the counter wraps to 0 or stops at 63. Training and dispatch are placed exactly on a clear cycle to show that the clear takes priority over both. A long random phase over a small PC and tag pool then crosses several clear periods and produces dense collisions between sets.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    // How a training event chooses the set number written to both entries
    typedef enum logic [1:0] {
        MRG_FRESH,      // neither side known: allocate
        MRG_USE_LOAD,   // only the load side known
        MRG_USE_STORE,  // only the store side known
        MRG_LOWER       // both known: keep the lower number
    } merge_e;

endpackage

// File: rtl/ssp_clear_timer.sv
module ssp_clear_timer #(
    parameter int INTERVAL = 65536
) (
    input  logic clk,
    input  logic rst_n,
    output logic clr_now
);
    localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        clr_now = (st_q.cnt == CW'(INTERVAL - 1));
        if (clr_now) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ssp_id_table.sv
module ssp_id_table #(
    parameter int IDX_W = 10,
    parameter int SET_W = 6,
    parameter int NRD   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_a_idx,
    input  logic [IDX_W-1:0]           wr_b_idx,
    input  logic [SET_W-1:0]           wr_id,
    input  logic [NRD-1:0][IDX_W-1:0]  rd_idx,
    output logic [NRD-1:0]             rd_vld,
    output logic [NRD-1:0][SET_W-1:0]  rd_id
);
    localparam int N = 1 << IDX_W;

    typedef struct packed {
        logic [N-1:0]            vld;
        logic [N-1:0][SET_W-1:0] sid;
    } st_t;

    st_t st_d, st_q;

    // Independent read ports, all looking at the registered state
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_vld[p] = st_q.vld[rd_idx[p]];
        assign rd_id[p]  = st_q.sid[rd_idx[p]];
    end

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.vld = '0;
        end else if (wr_en) begin
            st_d.vld[wr_a_idx] = 1'b1;
            st_d.sid[wr_a_idx] = wr_id;
            st_d.vld[wr_b_idx] = 1'b1;
            st_d.sid[wr_b_idx] = wr_id;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ssp_owner_table.sv
module ssp_owner_table #(
    parameter int SET_W = 6,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             disp_en,
    input  logic [SET_W-1:0] disp_set,
    input  logic [TAG_W-1:0] disp_tag,
    input  logic             res_en,
    input  logic [TAG_W-1:0] res_tag,
    input  logic [SET_W-1:0] rd_set,
    output logic             rd_busy
);
    localparam int M = 1 << SET_W;

    typedef struct packed {
        logic [M-1:0]            vld;
        logic [M-1:0][TAG_W-1:0] tag;
    } st_t;

    st_t        st_d, st_q;
    logic [M-1:0] hit;

    // One tag comparator per set entry
    for (genvar i = 0; i < M; i++) begin : g_cmp
        assign hit[i] = res_en && st_q.vld[i] && (st_q.tag[i] == res_tag);
    end

    assign rd_busy = st_q.vld[rd_set];

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.vld = '0;
        end else begin
            for (int i = 0; i < M; i++) begin
                if (hit[i]) begin
                    st_d.vld[i] = 1'b0;
                end
            end
            // a new owner overrides a release of the same set
            if (disp_en) begin
                st_d.vld[disp_set] = 1'b1;
                st_d.tag[disp_set] = disp_tag;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ssp_predictor.sv
module ssp_predictor
    import ssp_pkg::*;
#(
    parameter int PC_W         = 32,
    parameter int ALIGN        = 2,
    parameter int IDX_W        = 10,
    parameter int SET_W        = 6,
    parameter int TAG_W        = 8,
    parameter int CLR_INTERVAL = 65536
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trn_valid,
    input  logic [PC_W-1:0]  trn_load_pc,
    input  logic [PC_W-1:0]  trn_store_pc,
    input  logic             disp_valid,
    input  logic [PC_W-1:0]  disp_pc,
    input  logic [TAG_W-1:0] disp_tag,
    input  logic             res_valid,
    input  logic [TAG_W-1:0] res_tag,
    input  logic             lq_valid,
    input  logic [PC_W-1:0]  lq_pc,
    output logic             lq_stall
);
    localparam int NRD    = 4;
    localparam int RP_LD  = 0;
    localparam int RP_ST  = 1;
    localparam int RP_DSP = 2;
    localparam int RP_QRY = 3;

    typedef struct packed {
        logic [SET_W-1:0] alloc;
    } st_t;

    st_t st_d, st_q;

    logic                      clr_now;
    logic [NRD-1:0][IDX_W-1:0] rd_idx;
    logic [NRD-1:0]            rd_vld;
    logic [NRD-1:0][SET_W-1:0] rd_id;
    merge_e                    mrg;
    logic [SET_W-1:0]          train_id;
    logic                      train_en;
    logic                      disp_en;
    logic                      set_busy;
    logic [SET_W-1:0]          alloc_cur;
    logic                      unused_pc;

    assign unused_pc = ^{trn_load_pc, trn_store_pc, disp_pc, lq_pc};
    assign alloc_cur = st_q.alloc;

    assign rd_idx[RP_LD]  = trn_load_pc[ALIGN +: IDX_W];
    assign rd_idx[RP_ST]  = trn_store_pc[ALIGN +: IDX_W];
    assign rd_idx[RP_DSP] = disp_pc[ALIGN +: IDX_W];
    assign rd_idx[RP_QRY] = lq_pc[ALIGN +: IDX_W];

    ssp_clear_timer #(
        .INTERVAL (CLR_INTERVAL)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_now (clr_now)
    );

    always_comb begin
        unique case ({rd_vld[RP_LD], rd_vld[RP_ST]})
            2'b00:   mrg = MRG_FRESH;
            2'b10:   mrg = MRG_USE_LOAD;
            2'b01:   mrg = MRG_USE_STORE;
            default: mrg = MRG_LOWER;
        endcase

        unique case (mrg)
            MRG_FRESH:     train_id = st_q.alloc;
            MRG_USE_LOAD:  train_id = rd_id[RP_LD];
            MRG_USE_STORE: train_id = rd_id[RP_ST];
            default:       train_id = (rd_id[RP_LD] < rd_id[RP_ST]) ?
                                      rd_id[RP_LD] : rd_id[RP_ST];
        endcase

        train_en = trn_valid && !clr_now;
        disp_en  = disp_valid && rd_vld[RP_DSP] && !clr_now;

        st_d = st_q;
        if (train_en && (mrg == MRG_FRESH)) begin
            st_d.alloc = st_q.alloc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    ssp_id_table #(
        .IDX_W (IDX_W),
        .SET_W (SET_W),
        .NRD   (NRD)
    ) u_ids (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_now),
        .wr_en    (train_en),
        .wr_a_idx (rd_idx[RP_LD]),
        .wr_b_idx (rd_idx[RP_ST]),
        .wr_id    (train_id),
        .rd_idx   (rd_idx),
        .rd_vld   (rd_vld),
        .rd_id    (rd_id)
    );

    ssp_owner_table #(
        .SET_W (SET_W),
        .TAG_W (TAG_W)
    ) u_owner (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_now),
        .disp_en  (disp_en),
        .disp_set (rd_id[RP_DSP]),
        .disp_tag (disp_tag),
        .res_en   (res_valid),
        .res_tag  (res_tag),
        .rd_set   (rd_id[RP_QRY]),
        .rd_busy  (set_busy)
    );

    assign lq_stall = lq_valid && rd_vld[RP_QRY] && set_busy;
endmodule

// File: rtl/ssp_predictor_chk.sv
module ssp_predictor_chk #(
    parameter int SET_W    = 6,
    parameter int INTERVAL = 65536
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trn_valid,
    input logic             disp_valid,
    input logic             lq_valid,
    input logic             lq_stall,
    input logic             clr_now,
    input logic [SET_W-1:0] alloc_cur
);
    logic [31:0] ck_cnt;
    logic        seen_train;
    logic        seen_disp;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_cnt     <= '0;
            seen_train <= 1'b0;
            seen_disp  <= 1'b0;
        end else begin
            ck_cnt <= (ck_cnt == 32'(INTERVAL - 1)) ? '0 : ck_cnt + 1'b1;
            if (clr_now) begin
                seen_train <= 1'b0;
                seen_disp  <= 1'b0;
            end else begin
                if (trn_valid)  seen_train <= 1'b1;
                if (disp_valid) seen_disp  <= 1'b1;
            end
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lq_valid |-> !lq_stall);                                          // R1

    AST_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_train || !seen_disp) |-> !lq_stall);                        // R7

    AST_CLEAR_CADENCE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_now == (ck_cnt == 32'(INTERVAL - 1)));                          // R9

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_now) |-> !lq_stall);                                      // R9

    AST_ALLOC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_cur == $past(alloc_cur)) ||
        (alloc_cur == SET_W'($past(alloc_cur) + 1'b1)));                    // R3
endmodule

bind ssp_predictor ssp_predictor_chk #(
    .SET_W    (SET_W),
    .INTERVAL (CLR_INTERVAL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trn_valid  (trn_valid),
    .disp_valid (disp_valid),
    .lq_valid   (lq_valid),
    .lq_stall   (lq_stall),
    .clr_now    (clr_now),
    .alloc_cur  (alloc_cur)
);

// File: tb/ssp_predictor_test.sv
module ssp_predictor_test;
    localparam int INTV = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trn_valid = 1'b0;
    logic [31:0] trn_load_pc = '0;
    logic [31:0] trn_store_pc = '0;
    logic        disp_valid = 1'b0;
    logic [31:0] disp_pc = '0;
    logic [7:0]  disp_tag = '0;
    logic        res_valid = 1'b0;
    logic [7:0]  res_tag = '0;
    logic        lq_valid = 1'b0;
    logic [31:0] lq_pc = '0;
    logic        lq_stall;

    always #4 clk = ~clk;

    ssp_predictor #(.CLR_INTERVAL(INTV)) uut (
        .clk(clk), .rst_n(rst_n),
        .trn_valid(trn_valid), .trn_load_pc(trn_load_pc), .trn_store_pc(trn_store_pc),
        .disp_valid(disp_valid), .disp_pc(disp_pc), .disp_tag(disp_tag),
        .res_valid(res_valid), .res_tag(res_tag),
        .lq_valid(lq_valid), .lq_pc(lq_pc), .lq_stall(lq_stall)
    );

    // Behavioural reference: entry index -> set, set -> pending tag
    int    m_set[int];
    int    m_tag[int];
    int    m_alloc = 0;
    int    m_cnt = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    function automatic int pidx(logic [31:0] pc);
        return int'((pc >> 2) & 32'h3ff);
    endfunction

    task automatic model_edge();
        int  li, si, di, nid;
        bit  lv, sv, dv, clr;
        int  kill[$];
        clr   = (m_cnt == INTV - 1);
        m_cnt = clr ? 0 : m_cnt + 1;
        if (clr) begin
            m_set.delete();
            m_tag.delete();
            return;
        end
        li = pidx(trn_load_pc);
        si = pidx(trn_store_pc);
        di = pidx(disp_pc);
        lv = m_set.exists(li);
        sv = m_set.exists(si);
        dv = m_set.exists(di);
        nid = 0;
        if (trn_valid) begin
            if (!lv && !sv) begin
                nid = m_alloc;
                m_alloc = (m_alloc + 1) % 64;
            end else if (lv && !sv) nid = m_set[li];
            else if (!lv && sv)     nid = m_set[si];
            else nid = (m_set[li] < m_set[si]) ? m_set[li] : m_set[si];
        end
        if (res_valid) begin
            foreach (m_tag[k]) if (m_tag[k] == int'(res_tag)) kill.push_back(k);
            foreach (kill[j]) m_tag.delete(kill[j]);
        end
        if (disp_valid && dv) m_tag[m_set[di]] = int'(disp_tag);
        if (trn_valid) begin
            m_set[li] = nid;
            m_set[si] = nid;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_set.delete();
            m_tag.delete();
            m_alloc = 0;
            m_cnt   = 0;
        end else begin
            model_edge();
        end
    end

    function automatic bit exp_stall();
        int qi;
        qi = pidx(lq_pc);
        if (!lq_valid || !m_set.exists(qi)) return 1'b0;
        return m_tag.exists(m_set[qi]);
    endfunction

    // Compare away from the edge, then move to the next negedge
    task automatic tick();
        bit e;
        #1;
        e = exp_stall();
        n_cmp++;
        if (lq_stall !== e) begin
            n_bad++;
            $display("FAIL %s: lq_stall=%0b expected %0b (pc=%h t=%0t)",
                     cur_req, lq_stall, e, lq_pc, $time);
        end
        @(negedge clk);
        trn_valid  = 1'b0;
        disp_valid = 1'b0;
        res_valid  = 1'b0;
        lq_valid   = 1'b0;
    endtask

    task automatic train(input logic [31:0] l, input logic [31:0] s);
        trn_valid = 1'b1; trn_load_pc = l; trn_store_pc = s; tick();
    endtask
    task automatic disp(input logic [31:0] pc, input logic [7:0] t);
        disp_valid = 1'b1; disp_pc = pc; disp_tag = t; tick();
    endtask
    task automatic resolve(input logic [7:0] t);
        res_valid = 1'b1; res_tag = t; tick();
    endtask
    task automatic query(input logic [31:0] pc);
        lq_valid = 1'b1; lq_pc = pc; tick();
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        cur_req = "R1";
        query(32'h100);                 // during reset
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) query(32'h100 + 4 * i);
        tick();                          // no query: stall must be 0

        cur_req = "R3";                  // fresh pair gets set 0
        train(32'h100, 32'h200);
        cur_req = "R6";
        disp(32'h200, 8'd5);
        cur_req = "R7";
        query(32'h100);                  // stall
        query(32'h104);                  // unrelated: proceed
        cur_req = "R8";
        resolve(8'd6);                   // wrong tag: still stall
        query(32'h100);
        resolve(8'd5);
        query(32'h100);                  // released

        cur_req = "R2";                  // aliasing of index bits
        disp(32'h1200, 8'd1);
        query(32'h101);
        query(32'h1103);
        resolve(8'd1);
        query(32'h100);

        cur_req = "R6";                  // store with no set: no effect
        disp(32'h300, 8'd2);
        query(32'h300);
        query(32'h100);

        cur_req = "R4";
        train(32'h400, 32'h500);         // fresh set 1
        train(32'h600, 32'h200);         // load side adopts set 0
        disp(32'h200, 8'd3);
        query(32'h600);
        resolve(8'd3);
        cur_req = "R5";
        train(32'h400, 32'h200);         // 1 vs 0 -> 0
        disp(32'h500, 8'd4);             // set 1 pending
        query(32'h400);                  // now set 0: proceed
        disp(32'h200, 8'd7);
        query(32'h400);                  // stall

        cur_req = "R8";                  // dispatch beats resolve, same set
        disp_valid = 1'b1; disp_pc = 32'h200; disp_tag = 8'd8;
        res_valid = 1'b1; res_tag = 8'd7;
        tick();
        query(32'h100);
        resolve(8'd8);
        query(32'h100);
        resolve(8'd4);

        cur_req = "R3";                  // wrap the allocator
        for (int k = 0; k < 70; k++) train(32'h800 + 8 * k, 32'h804 + 8 * k);
        disp(32'h804, 8'd9);             // first pair's set
        query(32'h800);
        query(32'h800 + 8 * 64);         // wrapped pair may share it
        resolve(8'd9);

        cur_req = "R9";                  // clear cycle drops updates
        disp(32'h200, 8'd10);
        query(32'h100);
        while (m_cnt != INTV - 1) query(32'h100);
        trn_valid = 1'b1; trn_load_pc = 32'h700; trn_store_pc = 32'h704;
        disp_valid = 1'b1; disp_pc = 32'h704; disp_tag = 8'd11;
        lq_valid = 1'b1; lq_pc = 32'h100;
        tick();
        query(32'h100);
        disp(32'h704, 8'd12);
        query(32'h700);

        cur_req = "R7";                  // dense random traffic
        for (int n = 0; n < 4000; n++) begin
            trn_valid    = ($urandom_range(0, 15) == 0);
            trn_load_pc  = 32'h3000 + 4 * $urandom_range(0, 11);
            trn_store_pc = 32'h3000 + 4 * $urandom_range(0, 11);
            disp_valid   = ($urandom_range(0, 2) == 0);
            disp_pc      = 32'h3000 + 4 * $urandom_range(0, 11);
            disp_tag     = 8'($urandom_range(0, 15));
            res_valid    = ($urandom_range(0, 2) == 0);
            res_tag      = 8'($urandom_range(0, 15));
            lq_valid     = ($urandom_range(0, 3) != 0);
            lq_pc        = 32'h3000 + 4 * $urandom_range(0, 11);
            tick();
        end
        finish_run();
    end
endmodule